// File: doc/BRIEF.md
# Set-Bit Compaction Register

This block holds an 8-bit word and, once triggered, slides every set bit toward bit 0 until the ones form an unbroken run that starts at the bottom. When it finishes, the register holds a thermometer code whose length equals the number of ones that were loaded, so the block works as a slow, step-by-step counter of how many inputs were active.

A word is written through a parallel load port while the block is idle. A start pulse then begins compaction. On every step, each set bit whose lower neighbour is empty drops one place and its old position is cleared in that same step. All positions decide together from the state left by the previous step, so no one is ever duplicated or lost. A busy flag covers the steps still to come. A one-cycle done pulse marks the cycle in which the result is compact. A binary count derived from the thermometer result accompanies that pulse.

Top module: `bitpack_compactor`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears the register, `busy` and `done`. This includes a reset that arrives in the middle of a compaction.
- R2: A `load` pulse while idle (`busy` low) copies `loadData` into the register at that edge. A `load` while `busy` is high is ignored, and compaction goes on with the previous contents.
- R3: While idle, with neither `start` nor `load` asserted, the register keeps its value and `done` stays low.
- R4: Bit 0 is the lowest position. On each step, a set bit i (i ≥ 1) whose bit i-1 was clear after the previous step moves to i-1 and is cleared at i. Bit 0 never moves. For example, 0x11 steps through 0x09 and 0x05 to 0x03, and 0xC0 steps through 0xA0, 0x50, 0x28, 0x14, 0x0A and 0x05 to 0x03.
- R5: No step changes the number of set bits in the register.
- R6: `done` is high for exactly one cycle, in the cycle right after the last step. In that cycle `busy` is low and the register holds the thermometer code of the loaded population: ones in bits 0 to n-1 and zeros above.
- R7: A `start` while `busy` is high is ignored. The sequence of register values and the step count stay the same as if it had not occurred.
- R8: The first step is taken at the edge that samples `start` while idle, and one step follows at each further edge. `busy` is high from the step that leaves the word not yet compact until the edge of the last step. `done` appears no more than 7 cycles after the start edge: in the cycle right after it for a word that is already compact or all-zero (and `busy` never rises in that case), and after 7 steps for 0x80 or 0xFE.
- R9: While `done` is high, `countOut` gives, in binary, the number of ones in the register.
- R10: When `load` and `start` are both high in the same idle cycle, the load takes effect and the start is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe, honoured only while idle |
| loadData | input | 8 | Word written by `load` |
| start | input | 1 | Begins compaction when idle and not loading |
| regOut | output | 8 | Current register contents |
| busy | output | 1 | Further compaction steps are pending |
| done | output | 1 | One-cycle pulse: the register is compact |
| countOut | output | 4 | Binary count of ones, valid with `done` |

## Verification
The checker watches on every cycle that the population survives each step, that the register stays frozen while idle and untouched, that `done` only follows a step and comes with a thermometer-shaped register, a low `busy` and a matching count, and that no busy run lasts longer than the step bound allows. The exact position of each one after each step, the blocking between neighbours, and the total step count for the worst-case words can only be shown by the bench's traced scenarios. The same holds for the effect of starts and loads that arrive mid-run, the priority of load over start, and a reset during compaction.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

  // Strobes sent from the control unit to the datapath
  typedef struct packed {
    logic loadEn;   // write the parallel word into the register
    logic stepEn;   // apply one compaction step
  } strobe_t;

endpackage

// File: rtl/bitpack_datapath.sv
module bitpack_datapath
  import bitpack_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] regQ,
  output logic             nextCompact
);

  logic [WIDTH-1:0] moveFlag;   // bit i leaves position i this step
  logic [WIDTH-1:0] stepNext;   // register value after one step

  // Move rule: a bit drops when it is set and the position below is empty.
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : gen_move
      if (g == 0) begin : g_floor
        assign moveFlag[g] = 1'b0;
      end else begin : g_upper
        assign moveFlag[g] = regQ[g] & ~regQ[g-1];
      end
    end

    for (g = 0; g < WIDTH; g++) begin : gen_next
      if (g == WIDTH - 1) begin : g_top
        assign stepNext[g] = regQ[g] & ~moveFlag[g];
      end else begin : g_mid
        assign stepNext[g] = (regQ[g] & ~moveFlag[g]) | moveFlag[g+1];
      end
    end
  endgenerate

  // Look-ahead: after this step, would any bit still be able to move?
  assign nextCompact = ~|(stepNext[WIDTH-1:1] & ~stepNext[WIDTH-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ <= '0;
    end else if (strobes.loadEn) begin
      regQ <= loadData;
    end else if (strobes.stepEn) begin
      regQ <= stepNext;
    end
  end

endmodule

// File: rtl/bitpack_control.sv
module bitpack_control
  import bitpack_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    start,
  input  logic    nextCompact,
  output strobe_t strobes,
  output logic    busy,
  output logic    done
);

  logic idle;

  assign idle = ~busy;

  // Load wins over start; both are honoured only while idle.
  always_comb begin
    strobes.loadEn = load & idle;
    strobes.stepEn = busy | (idle & start & ~load);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strobes.stepEn & nextCompact;
      if (strobes.stepEn) begin
        busy <= ~nextCompact;
      end
    end
  end

endmodule

// File: rtl/bitpack_counter.sv
module bitpack_counter #(
  parameter int WIDTH    = 8,
  parameter int CNT_W    = 4,
  parameter bit COUNT_EN = 1'b1
) (
  input  logic [WIDTH-1:0] thermo,
  output logic [CNT_W-1:0] count
);

  generate
    if (COUNT_EN) begin : g_decode
      // Length of the run of ones that starts at bit 0
      always_comb begin
        logic runOn;
        runOn = 1'b1;
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
          runOn = runOn & thermo[i];
          if (runOn) begin
            count = CNT_W'(i + 1);
          end
        end
      end
    end else begin : g_none
      assign count = '0;
    end
  endgenerate

endmodule

// File: rtl/bitpack_compactor.sv
module bitpack_compactor
  import bitpack_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit COUNT_EN = 1'b1,
  localparam int CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] loadData,
  input  logic             start,
  output logic [WIDTH-1:0] regOut,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] countOut
);

  strobe_t strobes;
  logic    nextCompact;

  bitpack_control i_control (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .start       (start),
    .nextCompact (nextCompact),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  bitpack_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .loadData    (loadData),
    .regQ        (regOut),
    .nextCompact (nextCompact)
  );

  bitpack_counter #(.WIDTH(WIDTH), .CNT_W(CNT_W), .COUNT_EN(COUNT_EN)) i_counter (
    .thermo (regOut),
    .count  (countOut)
  );

endmodule

// File: rtl/bitpack_compactor_chk.sv
module bitpack_compactor_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             start,
  input logic [WIDTH-1:0] regOut,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] countOut
);

  localparam int RUN_W     = $clog2(WIDTH) + 1;
  localparam int BUSY_MAX  = WIDTH - 2;

  logic [WIDTH:0]     plusOne;
  logic               isThermo;
  logic [RUN_W-1:0]   runLen;

  assign plusOne  = {1'b0, regOut} + 1'b1;
  assign isThermo = (plusOne[WIDTH-1:0] & regOut) == '0;

  // Consecutive busy cycles seen before the current one (saturating)
  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      runLen <= '0;
    end else if (runLen != '1) begin
      runLen <= runLen + 1'b1;
    end
  end

  assert_pop_kept_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(load)) |-> ($countones(regOut) == $countones($past(regOut))));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !load) |=> ($stable(regOut) && !done));

  assert_done_shape_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (isThermo && !busy));

  assert_done_after_step_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) || $past(start)));

  assert_count_match_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (countOut == CNT_W'($countones(regOut))));

  assert_step_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (runLen < RUN_W'(BUSY_MAX)));

endmodule

bind bitpack_compactor bitpack_compactor_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .start    (start),
  .regOut   (regOut),
  .busy     (busy),
  .done     (done),
  .countOut (countOut)
);

// File: tb/test_bitpack_compactor.sv
`timescale 1ns/1ps
module test_bitpack_compactor;
  localparam int W  = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  loadData = '0;
  logic [W-1:0]  regOut;
  logic          busy;
  logic          done;
  logic [CW-1:0] countOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitpack_compactor i_bitpack_compactor (
    .clk(clk), .rst(rst), .load(load), .loadData(loadData), .start(start),
    .regOut(regOut), .busy(busy), .done(done), .countOut(countOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pop(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [W-1:0] thermo(input int n);
    logic [W-1:0] t = '0;
    for (int i = 0; i < n; i++) t[i] = 1'b1;
    return t;
  endfunction

  // All sampling and driving happens at the falling edge.
  task automatic doReset();
    @(negedge clk); rst = 1'b1; load = 1'b0; start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(regOut == '0, "R1", "reset regOut", int'(regOut), 0);
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    chk(!done, "R1", "reset done", int'(done), 0);
  endtask

  task automatic doLoad(input logic [W-1:0] v);
    @(negedge clk); loadData = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk(regOut == v, "R2", "load while idle", int'(regOut), int'(v));
  endtask

  task automatic testPattern(input logic [W-1:0] v, input int expSteps);
    int steps = 0;
    bit sawBusy = 1'b0;
    doLoad(v);
    @(negedge clk); start = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); start = 1'b0;
      chk(pop(regOut) == pop(v), "R5", "population per step", pop(regOut), pop(v));
      if (busy) sawBusy = 1'b1;
      if (done) begin steps = k; break; end
    end
    chk(steps >= 1 && steps <= 7, "R8", "step bound", steps, 7);
    if (expSteps >= 0)
      chk(steps == expSteps, "R8", "exact steps", steps, expSteps);
    if (expSteps == 1)
      chk(!sawBusy, "R8", "busy never rises for compact word", int'(sawBusy), 0);
    chk(regOut == thermo(pop(v)), "R6", "thermometer result", int'(regOut), int'(thermo(pop(v))));
    chk(!busy, "R6", "busy low with done", int'(busy), 0);
    chk(countOut == CW'(pop(v)), "R9", "binary count", int'(countOut), pop(v));
    @(negedge clk);
    chk(!done, "R6", "done is one cycle", int'(done), 0);
    chk(regOut == thermo(pop(v)), "R3", "result held", int'(regOut), int'(thermo(pop(v))));
  endtask

  task automatic traceSeq(input logic [W-1:0] v, input logic [W-1:0] seq [7], input int n);
    doLoad(v);
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); start = 1'b0;
      chk(regOut == seq[k], "R4", "step value", int'(regOut), int'(seq[k]));
      chk(done == (k == n - 1), "R6", "done timing", int'(done), int'(k == n - 1));
      chk(busy == (k != n - 1), "R8", "busy during steps", int'(busy), int'(k != n - 1));
    end
  endtask

  task automatic testTrace11();
    logic [W-1:0] s [7] = '{8'h09, 8'h05, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00};
    traceSeq(8'h11, s, 3);
  endtask

  task automatic testTraceC0();
    logic [W-1:0] s [7] = '{8'hA0, 8'h50, 8'h28, 8'h14, 8'h0A, 8'h05, 8'h03};
    traceSeq(8'hC0, s, 7);
  endtask

  task automatic testBusyInputs();
    doLoad(8'h80);
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    chk(regOut == 8'h40, "R4", "first step", int'(regOut), 8'h40);
    start = 1'b1; load = 1'b1; loadData = 8'hFF;
    @(negedge clk);
    start = 1'b0; load = 1'b0;
    chk(regOut == 8'h20, "R2", "load while busy ignored", int'(regOut), 8'h20);
    chk(busy, "R7", "start while busy keeps run", int'(busy), 1);
    for (int k = 3; k <= 7; k++) begin
      @(negedge clk);
      chk(regOut == W'(8'h80 >> k), "R7", "run unchanged by busy start", int'(regOut), int'(8'h80 >> k));
      chk(done == (k == 7), "R7", "done on 7th step", int'(done), int'(k == 7));
    end
  endtask

  task automatic testLoadStart();
    doLoad(8'h0F);
    @(negedge clk); load = 1'b1; start = 1'b1; loadData = 8'h80;
    @(negedge clk); load = 1'b0; start = 1'b0;
    chk(regOut == 8'h80, "R10", "load wins", int'(regOut), 8'h80);
    chk(!busy, "R10", "start ignored busy", int'(busy), 0);
    @(negedge clk);
    chk(regOut == 8'h80, "R10", "no step taken", int'(regOut), 8'h80);
    chk(!done, "R10", "no done", int'(done), 0);
  endtask

  task automatic testHold();
    doLoad(8'hA5);
    repeat (3) @(negedge clk);
    chk(regOut == 8'hA5, "R3", "idle hold", int'(regOut), 8'hA5);
    chk(!done, "R3", "idle done low", int'(done), 0);
  endtask

  task automatic testResetMid();
    doLoad(8'h80);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(regOut == '0, "R1", "mid-run reset regOut", int'(regOut), 0);
    chk(!busy, "R1", "mid-run reset busy", int'(busy), 0);
    chk(!done, "R1", "mid-run reset done", int'(done), 0);
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish();
    end
  end

  initial begin
    doReset();
    testHold();
    testTrace11();
    testTraceC0();
    testPattern(8'h00, 1);
    testPattern(8'h01, 1);
    testPattern(8'h0F, 1);
    testPattern(8'hFF, 1);
    testPattern(8'h80, 7);
    testPattern(8'hFE, 7);
    testPattern(8'h11, 3);
    testPattern(8'hAA, -1);
    testPattern(8'h55, -1);
    testPattern(8'h81, -1);
    testBusyInputs();
    testLoadStart();
    testResetMid();
    finished = 1'b1;
    finish();
  end

endmodule